// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps a 32-bit count of seconds that software reads and rewrites over a simple register bus. The bus has a write strobe, a read strobe, a byte address and a 32-bit data word in each direction. An external one-pulse-per-second tick advances the count. The count wraps from all ones back to zero. The oscillator and the prescaler that produce the tick sit outside the block.

A match register holds an alarm time. When the count and the match value become equal, a raw alarm flag sets. A count change, a load or a match write can each make them equal, and in every case the flag sets on the same clock edge. A one-bit mask gates the flag onto a level interrupt output. A clear register drops the flag, and a masked-status register reports the gated value. A control register always reads as enabled. Eight fixed identification bytes sit in the top 32 bytes of the 4 KB window.

Reads are registered. The strobe and address are presented in one cycle, and the data appears on the read bus after that clock edge. The data then holds until the next read. Neither strobe can stall, so the bus has no back-pressure.

Top module: `sec_rtc`

## Requirements
- R1: After synchronous reset the count, match, load, mask and raw-status registers all read 0 and `irq` is low.
- R2: On each clock edge with `tick_1hz` high, the count (read at offset 0x00) increases by one, and 0xFFFFFFFF wraps to 0.
- R3: A write to offset 0x08 sets the count to the written value, even if a tick arrives in the same cycle. A read of 0x08 returns the last value written there.
- R4: Offset 0x04 holds the match value and reads it back. The raw flag (bit 0 at offset 0x14) sets on the edge where a tick, a load write or a match write leaves the count equal to the match value.
- R5: The mask at offset 0x10 stores only written bit 0. Bits 31:1 read as zero.
- R6: A write to offset 0x1C with bit 0 set clears the raw flag, and the flag stays set when bit 0 is zero. A set in the same cycle wins over the clear. A read of 0x1C returns 0.
- R7: Offset 0x18 reads raw flag AND mask in bit 0, and `irq` equals the same AND.
- R8: Offset 0x0C always reads 1, and writes to it change nothing.
- R9: Word reads at 0xFE0, 0xFE4 … 0xFFC return 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, with the upper 24 bits zero.
- R10: Writes to offsets 0x00, 0x14 and 0x18 change no state. Reads of any offset not listed in R2 to R9 return 0.
- R11: `rdata` updates on the edge where `rd_en` is high and holds at all other times. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-second pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address within the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level alarm interrupt |

## Verification
The bound checker runs on every cycle. It covers the increment after a tick and the priority of a load over that tick. It also covers an immediate alarm after a match write that equals the count, and stable state after a write to the data offset. On reads, it checks that the masked status agrees with `irq`, that control reads 1, and that the upper mask bits are clear. Only the directed scenarios can show the wrap through zero, alarms raised by a load or by reaching the match through ticks, set-over-clear ordering, the identification bytes and unmapped reads.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  // byte offsets of the register window
  localparam int OFF_COUNT  = 'h00;
  localparam int OFF_MATCH  = 'h04;
  localparam int OFF_LOAD   = 'h08;
  localparam int OFF_CTRL   = 'h0C;
  localparam int OFF_MASK   = 'h10;
  localparam int OFF_RAW    = 'h14;
  localparam int OFF_MASKED = 'h18;
  localparam int OFF_CLEAR  = 'h1C;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_MATCH,
    SEL_LOAD,
    SEL_CTRL,
    SEL_MASK,
    SEL_RAW,
    SEL_MASKED,
    SEL_CLEAR,
    SEL_ID
  } reg_sel_e;

  // identification byte for word slot idx of the top 32 bytes
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h31;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  // load wins over the tick; the increment wraps naturally
  always_comb begin
    if (ld_en)      cnt_nxt = ld_val;
    else if (tick)  cnt_nxt = cnt_q + CNT_W'(1);
    else            cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_event,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             match_wr,
  input  logic             mask_wr,
  input  logic             clear_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] match_q,
  output logic             raw_q,
  output logic             mask_q,
  output logic             irq
);

  logic [CNT_W-1:0] match_nxt;
  logic             hit;
  logic             raw_d;

  assign match_nxt = match_wr ? wdata : match_q;
  // compare against the values that will hold after this edge
  assign hit       = (cnt_event || match_wr) && (cnt_nxt == match_nxt);

  always_comb begin
    raw_d = raw_q;
    if (clear_wr && wdata[0]) raw_d = 1'b0;
    if (hit)                  raw_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      raw_q   <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      match_q <= match_nxt;
      raw_q   <= raw_d;
      if (mask_wr) mask_q <= wdata[0];
    end
  end

  assign irq = raw_q & mask_q;

endmodule

// File: rtl/sec_rtc_rdmux.sv
module sec_rtc_rdmux
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [2:0]        id_idx,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic [DATA_W-1:0] match_q,
  input  logic [DATA_W-1:0] load_q,
  input  logic              mask_q,
  input  logic              raw_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_COUNT:  rd_mux = cnt_q;
      SEL_MATCH:  rd_mux = match_q;
      SEL_LOAD:   rd_mux = load_q;
      SEL_CTRL:   rd_mux = DATA_W'(1);
      SEL_MASK:   rd_mux = DATA_W'(mask_q);
      SEL_RAW:    rd_mux = DATA_W'(raw_q);
      SEL_MASKED: rd_mux = DATA_W'(raw_q & mask_q);
      SEL_ID:     rd_mux = DATA_W'(id_byte(id_idx));
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              in_id;
  reg_sel_e          sel;
  logic              unused_lsb;

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cnt_nxt;
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] load_q;
  logic              raw_q;
  logic              mask_q;

  logic load_wr, match_wr, mask_wr, clear_wr;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];
  // top 32 bytes of the window hold the identification words
  assign in_id      = &addr[ADDR_W-1:5];

  always_comb begin
    sel = SEL_NONE;
    if (in_id) begin
      sel = SEL_ID;
    end else begin
      case (word)
        WORD_W'(OFF_COUNT  >> 2): sel = SEL_COUNT;
        WORD_W'(OFF_MATCH  >> 2): sel = SEL_MATCH;
        WORD_W'(OFF_LOAD   >> 2): sel = SEL_LOAD;
        WORD_W'(OFF_CTRL   >> 2): sel = SEL_CTRL;
        WORD_W'(OFF_MASK   >> 2): sel = SEL_MASK;
        WORD_W'(OFF_RAW    >> 2): sel = SEL_RAW;
        WORD_W'(OFF_MASKED >> 2): sel = SEL_MASKED;
        WORD_W'(OFF_CLEAR  >> 2): sel = SEL_CLEAR;
        default:                  sel = SEL_NONE;
      endcase
    end
  end

  assign load_wr  = wr_en && (sel == SEL_LOAD);
  assign match_wr = wr_en && (sel == SEL_MATCH);
  assign mask_wr  = wr_en && (sel == SEL_MASK);
  assign clear_wr = wr_en && (sel == SEL_CLEAR);

  always_ff @(posedge clk) begin
    if (rst)          load_q <= '0;
    else if (load_wr) load_q <= wdata;
  end

  sec_rtc_counter #(.CNT_W(DATA_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_1hz),
    .ld_en   (load_wr),
    .ld_val  (wdata),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  sec_rtc_alarm #(.CNT_W(DATA_W)) u_alarm (
    .clk       (clk),
    .rst       (rst),
    .cnt_event (tick_1hz || load_wr),
    .cnt_nxt   (cnt_nxt),
    .match_wr  (match_wr),
    .mask_wr   (mask_wr),
    .clear_wr  (clear_wr),
    .wdata     (wdata),
    .match_q   (match_q),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  sec_rtc_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .sel     (sel),
    .id_idx  (addr[4:2]),
    .cnt_q   (cnt_q),
    .match_q (match_q),
    .load_q  (load_q),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .rdata   (rdata)
  );

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_1hz,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [DATA_W-1:0] cnt_q,
  input logic              raw_q
);

  localparam int WORD_W = ADDR_W - 2;

  logic seen;
  logic at_count, at_match, at_load, at_ctrl, at_mask, at_masked, low_page;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  assign low_page  = !(&addr[ADDR_W-1:5]);
  assign at_count  = low_page && addr[ADDR_W-1:2] == WORD_W'(OFF_COUNT  >> 2);
  assign at_match  = low_page && addr[ADDR_W-1:2] == WORD_W'(OFF_MATCH  >> 2);
  assign at_load   = low_page && addr[ADDR_W-1:2] == WORD_W'(OFF_LOAD   >> 2);
  assign at_ctrl   = low_page && addr[ADDR_W-1:2] == WORD_W'(OFF_CTRL   >> 2);
  assign at_mask   = low_page && addr[ADDR_W-1:2] == WORD_W'(OFF_MASK   >> 2);
  assign at_masked = low_page && addr[ADDR_W-1:2] == WORD_W'(OFF_MASKED >> 2);

  assert_tick_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (seen && tick_1hz && !(wr_en && at_load)) |=> cnt_q == DATA_W'($past(cnt_q) + DATA_W'(1)));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (seen && wr_en && at_load) |=> cnt_q == $past(wdata));

  assert_match_now_R4: assert property (@(posedge clk) disable iff (rst)
    (seen && wr_en && at_match && !tick_1hz && wdata == cnt_q) |=> raw_q);

  assert_mask_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (seen && rd_en && at_mask) |=> rdata[DATA_W-1:1] == '0);

  assert_masked_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (seen && rd_en && at_masked) |=> rdata == DATA_W'($past(irq)));

  assert_ctrl_one_R8: assert property (@(posedge clk) disable iff (rst)
    (seen && rd_en && at_ctrl) |=> rdata == DATA_W'(1));

  assert_count_ro_R10: assert property (@(posedge clk) disable iff (rst)
    (seen && wr_en && at_count && !tick_1hz) |=> $stable(cnt_q));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (seen && !rd_en) |=> $stable(rdata));

endmodule

bind sec_rtc sec_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_1hz (tick_1hz),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq      (irq),
  .cnt_q    (cnt_q),
  .raw_q    (raw_q)
);

// File: tb/test_sec_rtc.sv
module test_sec_rtc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sec_rtc i_sec_rtc (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R1 count", 12'h000, 0);
    rd_chk("R1 match", 12'h004, 0);
    rd_chk("R1 load",  12'h008, 0);
    rd_chk("R1 mask",  12'h010, 0);
    rd_chk("R1 raw",   12'h014, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count;
    ticks(3);
    rd_chk("R2 count after 3 ticks", 12'h000, 3);
    wr(12'h008, 32'hFFFF_FFFE);
    ticks(2);
    rd_chk("R2 wrap to zero", 12'h000, 0);
    rd_chk("R4 alarm on tick reaching match 0", 12'h014, 1);
  endtask

  task automatic t_load;
    wr(12'h01C, 1);
    wr(12'h008, 32'h1234_5678);
    rd_chk("R3 count loaded", 12'h000, 32'h1234_5678);
    rd_chk("R3 load readback", 12'h008, 32'h1234_5678);
    @(negedge clk); wr_en = 1'b1; tick_1hz = 1'b1; addr = 12'h008; wdata = 32'h0000_0040;
    @(negedge clk); wr_en = 1'b0; tick_1hz = 1'b0;
    rd_chk("R3 load wins over tick", 12'h000, 32'h40);
  endtask

  task automatic t_alarm;
    wr(12'h01C, 1);
    rd_chk("R6 raw cleared", 12'h014, 0);
    wr(12'h004, 32'h40);
    rd_chk("R4 match readback", 12'h004, 32'h40);
    rd_chk("R4 match write hits count", 12'h014, 1);
    wr(12'h01C, 1);
    wr(12'h004, 32'd500);
    wr(12'h008, 32'd500);
    rd_chk("R4 load write hits match", 12'h014, 1);
    wr(12'h01C, 1);
    wr(12'h004, 32'd10);
    wr(12'h008, 32'd8);
    ticks(1);
    rd_chk("R4 no alarm before match", 12'h014, 0);
    ticks(1);
    rd_chk("R4 alarm when tick reaches match", 12'h014, 1);
  endtask

  task automatic t_mask;
    check("R7 irq low while masked", {31'b0, irq}, 0);
    rd_chk("R7 masked status low", 12'h018, 0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd_chk("R5 mask keeps bit 0 only", 12'h010, 1);
    check("R7 irq high", {31'b0, irq}, 1);
    rd_chk("R7 masked status high", 12'h018, 1);
    wr(12'h01C, 32'h2);
    rd_chk("R6 clear without bit 0 keeps raw", 12'h014, 1);
    rd_chk("R6 clear register reads 0", 12'h01C, 0);
    wr(12'h01C, 32'h1);
    rd_chk("R6 clear drops raw", 12'h014, 0);
    check("R7 irq low after clear", {31'b0, irq}, 0);
    wr(12'h004, 32'd21);
    wr(12'h008, 32'd20);
    @(negedge clk); wr_en = 1'b1; tick_1hz = 1'b1; addr = 12'h01C; wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0; tick_1hz = 1'b0;
    rd_chk("R6 set wins over clear", 12'h014, 1);
    wr(12'h010, 32'h0);
    check("R7 irq low after unmask", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl_id;
    logic [7:0] exp_id [8];
    exp_id = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    wr(12'h00C, 32'h0);
    rd_chk("R8 control reads 1", 12'h00C, 1);
    for (int i = 0; i < 8; i++)
      rd_chk("R9 id byte", 12'hFE0 + 12'(i * 4), {24'b0, exp_id[i]});
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    wr(12'h008, 32'd77);
    wr(12'h000, 32'd5);
    rd_chk("R10 data write ignored", 12'h000, 32'd77);
    wr(12'h01C, 1);
    wr(12'h004, 32'd77);
    wr(12'h014, 32'h0);
    wr(12'h018, 32'h0);
    rd_chk("R10 raw/masked writes ignored", 12'h014, 1);
    rd_chk("R10 unmapped 0x020", 12'h020, 0);
    rd_chk("R10 unmapped 0x800", 12'h800, 0);
    rd_chk("R11 low address bits ignored", 12'h006, 32'd77);
    @(negedge clk); addr = 12'h00C;
    @(negedge clk); d = rdata;
    check("R11 rdata holds without strobe", d, 32'd77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_load();
    t_alarm();
    t_mask();
    t_ctrl_id();
    t_readonly();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule